// File: doc/BRIEF.md
# Hardware Cursor Overlay Generator

This block draws a hardware cursor on top of a pixel stream. A host loads two bit-plane maps (an image plane and a shape plane) through an auto-incrementing byte port. It also sets the cursor position, a size bit, a 2-bit rendering mode and three overlay colours. On the video side the block takes the current pixel coordinates, an active-video flag and the underlying RGB value. One clock later it returns the composed RGB value.

The cursor is anchored by its bottom-right corner. The position registers name the rightmost column and the lowest scanline that the cursor covers. Within each map byte the most significant bit is the leftmost pixel, and the rows of each plane are stored one after another. Host writes use a 4-bit register select, an 8-bit data bus and a write strobe.

Overlay colours are loaded by a three-state loader with states `LD_RED`, `LD_GRN` and `LD_BLU`:
- A colour data write moves `LD_RED` to `LD_GRN`, `LD_GRN` to `LD_BLU`, and `LD_BLU` back to `LD_RED`.
- The step from `LD_BLU` back to `LD_RED` also advances the colour entry index.
- A write to the colour index register forces the loader to `LD_RED` from any state.
- Reset places the loader in `LD_RED`.

Top module: `hwcursor_overlay`

## Requirements
- R1: While reset is asserted, `pix_out` is 0. After reset the mode is off, so an active pixel passes through unchanged.
- R2: Select 1 writes data[1:0] into map pointer bits 9:8, and select 0 writes data[7:0] into pointer bits 7:0. Each write to select 2 stores the byte at the pointer, then adds one to the pointer. The pointer wraps from 1023 to 0.
- R3: The control register is select 3, with data[0] as the size bit and data[2:1] as the mode. With the size bit clear the cursor is 32x32. Its image plane sits at map bytes 0..127 and its shape plane at bytes 128..255. Pixel (row r, column c) is in byte r*4+c/8, at bit 7-(c mod 8).
- R4: With the size bit set the cursor is 64x64. Its image plane sits at bytes 0..511 and its shape plane at bytes 512..1023. Pixel (r, c) is in byte r*8+c/8, at bit 7-(c mod 8).
- R5: Selects 4 and 5 set the 12-bit X position (bits 7:0, then bits 11:8 from data[3:0]). Selects 6 and 7 set the 12-bit Y position in the same way. For cursor size D, the cursor covers columns X-D+1..X and rows Y-D+1..Y.
- R6: Modes 0 and 1 show no cursor, so an active pixel passes through.
- R7: In modes 2 and 3, a shape bit of 0 is transparent. A shape bit of 1 shows the foreground colour (entry 2) when the image bit is 1, and the background colour (entry 1) when it is 0.
- R8: Select 8 sets the colour entry index from data[1:0], where 3 maps to 0, and restarts the loader at red. Each write to select 9 fills the red, then green, then blue byte of the entry. After blue the index advances, and 2 wraps to 0. Colours are output as {R,G,B}, with R in bits 23:16.
- R9: When `vid_active` is low the output is the overscan colour (entry 0), whatever the cursor state.
- R10: `pix_out` is registered, so it reflects the inputs sampled at the previous rising clock edge.
- R11: The cursor never wraps past coordinate 0. With X or Y smaller than D-1, only the columns 0..X or rows 0..Y are drawn, and pixels right of X or below Y pass through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 4 | Host register select |
| host_wdata | input | 8 | Host write data |
| vid_active | input | 1 | High inside the visible area |
| pix_x | input | 12 | Current pixel column |
| pix_y | input | 12 | Current pixel row |
| pix_in | input | 24 | Underlying RGB value |
| pix_out | output | 24 | Composed RGB value, one cycle later |

## Verification
The bench fills the whole map with an address-derived byte pattern, then sweeps every pixel of a window a few pixels larger than the cursor. It does this for the small size in both drawing modes and for the large size. The sweeps separate the plane offsets, the row strides and the bit order within each byte, and they catch off-by-one errors at all four cursor edges. A second sweep after writes that cross the top of the map shows that the pointer wraps. Sweeps with the mode set to 0 and 1, with a cursor placed near the origin, and with blanking set tell apart the transparent, clipped and overscan cases. A colour index rewrite in the middle of an entry checks that the loader restarts at red.

// File: rtl/hwcur_pkg.sv
package hwcur_pkg;

    typedef enum logic [3:0] {
        SEL_MPTR_LO = 4'd0,
        SEL_MPTR_HI = 4'd1,
        SEL_MDATA   = 4'd2,
        SEL_CTRL    = 4'd3,
        SEL_X_LO    = 4'd4,
        SEL_X_HI    = 4'd5,
        SEL_Y_LO    = 4'd6,
        SEL_Y_HI    = 4'd7,
        SEL_CIDX    = 4'd8,
        SEL_CDATA   = 4'd9
    } host_sel_e;

    typedef enum logic [1:0] {
        LD_RED = 2'd0,
        LD_GRN = 2'd1,
        LD_BLU = 2'd2
    } ld_state_e;

    localparam logic [1:0] MODE_OFF   = 2'd0;
    localparam logic [1:0] MODE_OFF_B = 2'd1;
    localparam logic [1:0] MODE_DRAW  = 2'd2;
    localparam logic [1:0] MODE_DRAWB = 2'd3;

endpackage

// File: rtl/hwcur_regs.sv
module hwcur_regs
    import hwcur_pkg::*;
#(
    parameter int PW = 12,
    parameter int CW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [3:0]      wr_sel,
    input  logic [7:0]      wr_data,
    output logic [PW-1:0]   cur_x,
    output logic [PW-1:0]   cur_y,
    output logic            big,
    output logic [1:0]      mode,
    output logic [3*CW-1:0] col_ovs,
    output logic [3*CW-1:0] col_bg,
    output logic [3*CW-1:0] col_fg
);

    localparam int HW = PW - 8;

    ld_state_e      ld_q, ld_d;
    logic [1:0]     idx_q;
    logic [3*CW-1:0] col_q [3];

    wire cidx_wr  = wr_en && (wr_sel == SEL_CIDX);
    wire cdata_wr = wr_en && (wr_sel == SEL_CDATA);

    always_comb begin
        ld_d = ld_q;
        if (cidx_wr) begin
            ld_d = LD_RED;
        end else if (cdata_wr) begin
            unique case (ld_q)
                LD_RED:  ld_d = LD_GRN;
                LD_GRN:  ld_d = LD_BLU;
                LD_BLU:  ld_d = LD_RED;
                default: ld_d = LD_RED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ld_q <= LD_RED;
        else        ld_q <= ld_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= 2'd0;
            for (int e = 0; e < 3; e++) col_q[e] <= '0;
        end else if (cidx_wr) begin
            idx_q <= (wr_data[1:0] == 2'd3) ? 2'd0 : wr_data[1:0];
        end else if (cdata_wr) begin
            for (int e = 0; e < 3; e++) begin
                if (idx_q == 2'(e)) begin
                    unique case (ld_q)
                        LD_RED:  col_q[e][3*CW-1:2*CW] <= wr_data[CW-1:0];
                        LD_GRN:  col_q[e][2*CW-1:CW]   <= wr_data[CW-1:0];
                        default: col_q[e][CW-1:0]      <= wr_data[CW-1:0];
                    endcase
                end
            end
            if (ld_q == LD_BLU) idx_q <= (idx_q == 2'd2) ? 2'd0 : idx_q + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_x <= '0;
            cur_y <= '0;
            big   <= 1'b0;
            mode  <= MODE_OFF;
        end else if (wr_en) begin
            unique case (wr_sel)
                SEL_CTRL: begin
                    big  <= wr_data[0];
                    mode <= wr_data[2:1];
                end
                SEL_X_LO: cur_x[7:0]    <= wr_data;
                SEL_X_HI: cur_x[PW-1:8] <= wr_data[HW-1:0];
                SEL_Y_LO: cur_y[7:0]    <= wr_data;
                SEL_Y_HI: cur_y[PW-1:8] <= wr_data[HW-1:0];
                default: ;
            endcase
        end
    end

    assign col_ovs = col_q[0];
    assign col_bg  = col_q[1];
    assign col_fg  = col_q[2];

    p_idx_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q != 2'd3);

    p_idx_advance_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cdata_wr && ld_q == LD_BLU) |=>
            idx_q == (($past(idx_q) == 2'd2) ? 2'd0 : $past(idx_q) + 2'd1));

    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cidx_wr |=> ld_q == LD_RED);

endmodule

// File: rtl/hwcur_map.sv
module hwcur_map
    import hwcur_pkg::*;
#(
    parameter int MAX_DIM = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_lo,
    input  logic                set_hi,
    input  logic                push,
    input  logic [7:0]          wdata,
    input  logic [$clog2(2*MAX_DIM*MAX_DIM/8)-1:0] img_addr,
    input  logic [$clog2(2*MAX_DIM*MAX_DIM/8)-1:0] shp_addr,
    output logic [7:0]          img_byte,
    output logic [7:0]          shp_byte
);

    localparam int NBYTES = 2 * MAX_DIM * MAX_DIM / 8;
    localparam int AW     = $clog2(NBYTES);

    logic [7:0]    mem [NBYTES];
    logic [AW-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (set_lo) begin
            ptr_q[7:0] <= wdata;
        end else if (set_hi) begin
            ptr_q[AW-1:8] <= wdata[AW-9:0];
        end else if (push) begin
            ptr_q <= ptr_q + AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[ptr_q] <= wdata;
    end

    assign img_byte = mem[img_addr];
    assign shp_byte = mem[shp_addr];

    p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !set_lo && !set_hi) |=> ptr_q == $past(ptr_q) + AW'(1));

endmodule

// File: rtl/hwcur_pixel.sv
module hwcur_pixel
    import hwcur_pkg::*;
#(
    parameter int MAX_DIM = 64,
    parameter int MIN_DIM = 32,
    parameter int PW      = 12,
    parameter int CW      = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PW-1:0]   cur_x,
    input  logic [PW-1:0]   cur_y,
    input  logic            big,
    input  logic [1:0]      mode,
    input  logic [3*CW-1:0] col_ovs,
    input  logic [3*CW-1:0] col_bg,
    input  logic [3*CW-1:0] col_fg,
    input  logic            vid_active,
    input  logic [PW-1:0]   pix_x,
    input  logic [PW-1:0]   pix_y,
    input  logic [3*CW-1:0] pix_in,
    output logic [$clog2(2*MAX_DIM*MAX_DIM/8)-1:0] img_addr,
    output logic [$clog2(2*MAX_DIM*MAX_DIM/8)-1:0] shp_addr,
    input  logic [7:0]      img_byte,
    input  logic [7:0]      shp_byte,
    output logic [3*CW-1:0] pix_out
);

    localparam int AW        = $clog2(2 * MAX_DIM * MAX_DIM / 8);
    localparam int CB        = $clog2(MAX_DIM);
    localparam int BIG_BYTES = MAX_DIM * MAX_DIM / 8;
    localparam int SML_BYTES = MIN_DIM * MIN_DIM / 8;
    localparam int BIG_SH    = $clog2(MAX_DIM / 8);
    localparam int SML_SH    = $clog2(MIN_DIM / 8);

    logic [PW:0]   dim_m1, dx, dy;
    logic          in_x, in_y, shp_bit, img_bit, hit;
    logic [CB-1:0] col, row;
    logic [AW-1:0] row_off;
    logic [2:0]    bsel;

    always_comb begin
        dim_m1  = big ? (PW+1)'(MAX_DIM - 1) : (PW+1)'(MIN_DIM - 1);
        dx      = {1'b0, cur_x} - {1'b0, pix_x};
        dy      = {1'b0, cur_y} - {1'b0, pix_y};
        in_x    = !dx[PW] && (dx <= dim_m1);
        in_y    = !dy[PW] && (dy <= dim_m1);
        col     = CB'(dim_m1) - CB'(dx);
        row     = CB'(dim_m1) - CB'(dy);
        row_off = big ? (AW'(row) << BIG_SH) : (AW'(row) << SML_SH);
        img_addr = row_off + AW'(col >> 3);
        shp_addr = img_addr + (big ? AW'(BIG_BYTES) : AW'(SML_BYTES));
        bsel    = ~col[2:0];
        img_bit = img_byte[bsel];
        shp_bit = shp_byte[bsel];
        hit     = in_x && in_y && shp_bit && (mode inside {MODE_DRAW, MODE_DRAWB});
    end

    always_ff @(posedge clk) begin
        if (!rst_n)          pix_out <= '0;
        else if (!vid_active) pix_out <= col_ovs;
        else if (hit)         pix_out <= img_bit ? col_fg : col_bg;
        else                  pix_out <= pix_in;
    end

    p_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !vid_active |=> pix_out == $past(col_ovs));

    p_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_active && !mode[1]) |=> pix_out == $past(pix_in));

    p_right_clip_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_active && pix_x > cur_x) |=> pix_out == $past(pix_in));

    p_below_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_active && pix_y > cur_y) |=> pix_out == $past(pix_in));

endmodule

// File: rtl/hwcursor_overlay.sv
module hwcursor_overlay
    import hwcur_pkg::*;
#(
    parameter int MAX_DIM = 64,
    parameter int MIN_DIM = 32,
    parameter int PW      = 12,
    parameter int CW      = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_we,
    input  logic [3:0]      host_sel,
    input  logic [7:0]      host_wdata,
    input  logic            vid_active,
    input  logic [PW-1:0]   pix_x,
    input  logic [PW-1:0]   pix_y,
    input  logic [3*CW-1:0] pix_in,
    output logic [3*CW-1:0] pix_out
);

    localparam int AW = $clog2(2 * MAX_DIM * MAX_DIM / 8);

    logic [PW-1:0]   cur_x, cur_y;
    logic            big;
    logic [1:0]      mode;
    logic [3*CW-1:0] col_ovs, col_bg, col_fg;
    logic [AW-1:0]   img_addr, shp_addr;
    logic [7:0]      img_byte, shp_byte;

    wire set_lo = host_we && (host_sel == SEL_MPTR_LO);
    wire set_hi = host_we && (host_sel == SEL_MPTR_HI);
    wire push   = host_we && (host_sel == SEL_MDATA);

    hwcur_regs #(.PW(PW), .CW(CW)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(host_we), .wr_sel(host_sel), .wr_data(host_wdata),
        .cur_x(cur_x), .cur_y(cur_y), .big(big), .mode(mode),
        .col_ovs(col_ovs), .col_bg(col_bg), .col_fg(col_fg)
    );

    hwcur_map #(.MAX_DIM(MAX_DIM)) map_i (
        .clk(clk), .rst_n(rst_n),
        .set_lo(set_lo), .set_hi(set_hi), .push(push), .wdata(host_wdata),
        .img_addr(img_addr), .shp_addr(shp_addr),
        .img_byte(img_byte), .shp_byte(shp_byte)
    );

    hwcur_pixel #(.MAX_DIM(MAX_DIM), .MIN_DIM(MIN_DIM), .PW(PW), .CW(CW)) pix_i (
        .clk(clk), .rst_n(rst_n),
        .cur_x(cur_x), .cur_y(cur_y), .big(big), .mode(mode),
        .col_ovs(col_ovs), .col_bg(col_bg), .col_fg(col_fg),
        .vid_active(vid_active), .pix_x(pix_x), .pix_y(pix_y), .pix_in(pix_in),
        .img_addr(img_addr), .shp_addr(shp_addr),
        .img_byte(img_byte), .shp_byte(shp_byte),
        .pix_out(pix_out)
    );

endmodule

// File: tb/hwcursor_overlay_tb_top.sv
module hwcursor_overlay_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [3:0]  host_sel = '0;
    logic [7:0]  host_wdata = '0;
    logic        vid_active = 1'b0;
    logic [11:0] pix_x = '0;
    logic [11:0] pix_y = '0;
    logic [23:0] pix_in = '0;
    logic [23:0] pix_out;

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0]  mem_m [1024];
    logic [23:0] col_m [3];
    int          cx = 0, cy = 0, mode_m = 0;
    bit          big_m = 0;

    always #10 clk = ~clk;

    hwcursor_overlay dut_i (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .vid_active(vid_active), .pix_x(pix_x),
        .pix_y(pix_y), .pix_in(pix_in), .pix_out(pix_out)
    );

    task automatic chk(string req, logic [23:0] act, logic [23:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(int sel, int data);
        @(negedge clk);
        host_we = 1'b1; host_sel = 4'(sel); host_wdata = 8'(data);
        @(negedge clk);
        host_we = 1'b0;
    endtask

    function automatic logic [7:0] pat(int a);
        return 8'((a * 73) + ((a >> 4) * 5) + 3);
    endfunction

    function automatic logic [23:0] bg_of(int x, int y);
        return {8'(x) ^ 8'h5A, 8'(y), 8'(x + y)};
    endfunction

    function automatic logic [23:0] model(int x, int y, bit act);
        int d, mb, c, r, a, b;
        if (!act) return col_m[0];
        d  = big_m ? 64 : 32;
        mb = big_m ? 512 : 128;
        if (mode_m >= 2 && x <= cx && x > cx - d && y <= cy && y > cy - d) begin
            c = x - (cx - d + 1);
            r = y - (cy - d + 1);
            a = r * (d / 8) + c / 8;
            b = 7 - (c % 8);
            if (mem_m[a + mb][b]) return mem_m[a][b] ? col_m[2] : col_m[1];
        end
        return bg_of(x, y);
    endfunction

    task automatic px(int x, int y, bit act, string req);
        @(negedge clk);
        pix_x = 12'(x); pix_y = 12'(y); vid_active = act; pix_in = bg_of(x, y);
        @(negedge clk);
        chk(req, pix_out, model(x, y, act));
    endtask

    task automatic sweep(int x0, int x1, int y0, int y1, string req);
        for (int y = y0; y <= y1; y++)
            for (int x = x0; x <= x1; x++)
                px(x, y, 1'b1, req);
    endtask

    task automatic set_ctrl(bit b, int m);
        wr(3, {5'b0, 2'(m), b});
        big_m = b; mode_m = m;
    endtask

    task automatic set_pos(int x, int y);
        wr(4, x & 255); wr(5, (x >> 8) & 15);
        wr(6, y & 255); wr(7, (y >> 8) & 15);
        cx = x; cy = y;
    endtask

    task automatic col_bytes(logic [23:0] v);
        wr(9, v[23:16]); wr(9, v[15:8]); wr(9, v[7:0]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R10: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) col_m[i] = '0;
        pix_in = 24'hABCDEF; vid_active = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 reset output", pix_out, 24'h0);
        rst_n = 1'b1;
        px(7, 9, 1'b1, "R1 pass after reset");
        px(700, 300, 1'b1, "R1 pass after reset");

        // R8: colour loading, index restart, wrap to entry 0
        wr(8, 1);
        col_bytes(24'h1122AA);            // entry 1
        col_bytes(24'hC0FFEE);            // entry 2
        wr(8, 2);
        wr(9, 8'h99); wr(9, 8'h98);       // abandoned partial entry 2
        wr(8, 2);
        col_bytes(24'hF0E0D0);            // entry 2 again from red
        col_bytes(24'h304050);            // wraps to entry 0
        col_m[0] = 24'h304050; col_m[1] = 24'h1122AA; col_m[2] = 24'hF0E0D0;
        wr(8, 3);                         // index 3 maps to 0
        col_bytes(24'h0A0B0C);
        col_m[0] = 24'h0A0B0C;
        px(5, 5, 1'b0, "R9 R8 overscan colour");

        // R2: load full map from address 0
        wr(1, 0); wr(0, 0);
        for (int a = 0; a < 1024; a++) begin
            wr(2, pat(a));
            mem_m[a] = pat(a);
        end

        // R6: modes 0 and 1 show nothing
        set_pos(100, 60);
        set_ctrl(0, 0);
        sweep(66, 102, 26, 30, "R6 mode 0");
        set_ctrl(0, 1);
        sweep(66, 102, 26, 30, "R6 mode 1");

        // R3 R5 R7: 32x32 in both drawing modes
        set_ctrl(0, 2);
        sweep(66, 103, 26, 63, "R3 R5 R7 small mode 2");
        set_ctrl(0, 3);
        sweep(66, 103, 26, 63, "R3 R5 R7 small mode 3");
        for (int i = 0; i < 4; i++) px(80 + i, 40, 1'b0, "R9 blank over cursor");

        // R10: output holds until the next rising edge
        px(90, 50, 1'b1, "R10 setup");
        @(negedge clk);
        pix_x = 12'd3; pix_y = 12'd3; pix_in = bg_of(3, 3);
        #2 chk("R10 held before edge", pix_out, model(90, 50, 1'b1));
        @(negedge clk);
        chk("R10 after edge", pix_out, model(3, 3, 1'b1));

        // R4: 64x64
        set_ctrl(1, 2);
        set_pos(200, 150);
        sweep(134, 202, 84, 152, "R4 R5 large");

        // R2: pointer wrap from 1022 across 1023 to 0
        wr(1, 3); wr(0, 8'hFE);
        for (int k = 0; k < 4; k++) begin
            wr(2, 8'h5C ^ (k * 8'h33));
            mem_m[(1022 + k) % 1024] = 8'(8'h5C ^ (k * 8'h33));
        end
        sweep(134, 201, 87, 88, "R2 wrap first rows");
        sweep(134, 201, 149, 151, "R2 wrap last rows");

        // R11: clipped near the origin
        set_ctrl(0, 2);
        set_pos(10, 5);
        sweep(0, 14, 0, 8, "R11 clip near origin");
        set_ctrl(1, 3);
        set_pos(3, 40);
        sweep(0, 6, 0, 42, "R11 clip large");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule